// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block carries an 18-bit word from port A to port B and, through a separate copy of the same logic, from port B to port A. Each direction has its own storage word and four controls: an active-low drive enable, a latch enable, a transfer clock and an active-low clock enable. With the latch enable high the direction is transparent: the output follows the input. With the latch enable low the stored word is held. A rising edge on the transfer clock reloads the stored word, but only while the clock enable is low.

The block runs on a system clock `clk_i`. The transfer clocks are level inputs sampled on that clock. A rising edge is a high sample that follows a low sample. The data output of each port comes with a drive-enable output, which a pad ring can use to steer a tri-state buffer. The stored word keeps updating while a port is not driving. Arbitration between the two directions belongs to the user.

Top module: `xcvr_top`

## Requirements
- R1: The A-to-B path (inputs `a_i`, `ab_*`; outputs `b_o`, `b_oe_o`) and the B-to-A path (inputs `b_i`, `ba_*`; outputs `a_o`, `a_oe_o`) are independent. While one path is exercised, the other path's output holds.
- R2: While a path's active-low drive enable is 1, its `*_oe_o` output is 0, whatever the other inputs do. While the drive enable is 0 and reset is released, `*_oe_o` is 1.
- R3: While the latch enable is 1, the data output equals the data input in the same cycle. The transfer clock and the clock enable have no effect.
- R4: While the latch enable is 0 and no rising transfer-clock edge is sampled, the data output keeps its previous value. This holds for the clock steady low, steady high or falling, and for any input data.
- R5: When the latch enable is 0, the clock enable is 0 and a rising transfer-clock edge is sampled on a `clk_i` edge, the input word present at that edge is stored. It appears on the output right after that edge and stays there.
- R6: When a rising transfer-clock edge is sampled while the clock enable is 1, the stored word does not change.
- R7: Captures still update the stored word while the drive enable is 1. When the drive enable returns to 0, the output shows the latest stored word.
- R8: When the latch enable falls, the output holds the input word that was sampled on the last `clk_i` edge with the latch enable high.
- R9: While `rst_ni` is 0, both stored words are 0 and both `*_oe_o` outputs are 0. After reset is released, with the latch enable 0, each output shows 0 until the next capture.
- R10: All 18 data bits move in both directions, including the all-ones word and the two end bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | Word arriving on port A |
| b_i | input | 18 | Word arriving on port B |
| ab_oe_ni | input | 1 | A-to-B drive enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk_i | input | 1 | A-to-B transfer clock, sampled on `clk_i` |
| ab_ce_ni | input | 1 | A-to-B clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A drive enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk_i | input | 1 | B-to-A transfer clock, sampled on `clk_i` |
| ba_ce_ni | input | 1 | B-to-A clock enable, active low |
| a_o | output | 18 | Word driven toward port A |
| a_oe_o | output | 1 | Drive enable for port A |
| b_o | output | 18 | Word driven toward port B |
| b_oe_o | output | 1 | Drive enable for port B |

## Verification
A wrong stored word is hidden while the latch enable is high. It shows on the data output in the first cycle the latch enable is low, so every hold check follows a latch-enable fall or a capture. A missed or spurious edge detection shows as a wrong output right after the `clk_i` edge that samples the transfer-clock transition, so each edge case is checked in that cycle. A capture made while the port is not driving is checked in the first cycle after the drive enable returns to 0.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;
  localparam int unsigned XCVR_DIRS = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic clk;
    logic ce_n;
  } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         le_i,
  input  logic         rise_i,
  input  logic         ce_ni,
  output logic [W-1:0] q_o
);
  logic         load;
  logic [W-1:0] q_q;

  // transparent phase keeps tracking; a clock capture needs le low and ce asserted
  assign load = le_i | (rise_i & ~ce_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (load) q_q <= din_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  xcvr_ctl_t    ctl_i,
  output logic [W-1:0] dout_o,
  output logic         oe_o
);
  logic         rise_w;
  logic [W-1:0] held_w;
  logic         live_q;

  xcvr_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctl_i.clk),
    .rise_o (rise_w)
  );

  xcvr_store #(.W(W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_i),
    .le_i   (ctl_i.le),
    .rise_i (rise_w),
    .ce_ni  (ctl_i.ce_n),
    .q_o    (held_w)
  );

  assign dout_o = ctl_i.le ? din_i : held_w;
  assign oe_o   = rst_ni & ~ctl_i.oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.le && !rise_w) |=> (ctl_i.le || $stable(dout_o))); // R4

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.le && rise_w && !ctl_i.ce_n) |=> (ctl_i.le || dout_o == $past(din_i))); // R5

  AST_GATED_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.le && rise_w && ctl_i.ce_n) |=> (ctl_i.le || $stable(dout_o))); // R6

  AST_LE_FALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $fell(ctl_i.le)) |-> (dout_o == $past(din_i))); // R8
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  input  logic         ba_ce_ni,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  // index 0 carries A to B, index 1 carries B to A
  logic [W-1:0] din_w  [XCVR_DIRS];
  logic [W-1:0] dout_w [XCVR_DIRS];
  logic         oe_w   [XCVR_DIRS];
  xcvr_ctl_t    ctl_w  [XCVR_DIRS];

  assign din_w[0] = a_i;
  assign din_w[1] = b_i;
  assign ctl_w[0] = '{oe_n: ab_oe_ni, le: ab_le_i, clk: ab_clk_i, ce_n: ab_ce_ni};
  assign ctl_w[1] = '{oe_n: ba_oe_ni, le: ba_le_i, clk: ba_clk_i, ce_n: ba_ce_ni};

  for (genvar d = 0; d < XCVR_DIRS; d++) begin : g_dir
    xcvr_path #(.W(W)) u_path (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (din_w[d]),
      .ctl_i  (ctl_w[d]),
      .dout_o (dout_w[d]),
      .oe_o   (oe_w[d])
    );
  end

  assign b_o    = dout_w[0];
  assign b_oe_o = oe_w[0];
  assign a_o    = dout_w[1];
  assign a_oe_o = oe_w[1];
endmodule

// File: tb/tb_xcvr_top.sv
module tb_xcvr_top;
  localparam int W = 18;
  localparam logic [3:0] HOLD_CTL = 4'b0001; // {oe_n, le, clk, ce_n}

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_ni;
  logic [W-1:0] a_i, b_i, a_o, b_o;
  logic         ab_oe_ni, ab_le_i, ab_clk_i, ab_ce_ni;
  logic         ba_oe_ni, ba_le_i, ba_clk_i, ba_ce_ni;
  logic         a_oe_o, b_oe_o;

  xcvr_top #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .ab_oe_ni(ab_oe_ni), .ab_le_i(ab_le_i), .ab_clk_i(ab_clk_i), .ab_ce_ni(ab_ce_ni),
    .ba_oe_ni(ba_oe_ni), .ba_le_i(ba_le_i), .ba_clk_i(ba_clk_i), .ba_ce_ni(ba_ce_ni),
    .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  typedef struct {
    logic [W-1:0] a;
    logic         aoe;
    logic [W-1:0] b;
    logic         boe;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;
  logic [W-1:0] m_st [2];
  logic         m_cp [2];

  function automatic void model(input int d, input logic [W-1:0] din, input logic [3:0] c,
                                output logic [W-1:0] o, output logic oe);
    logic rise;
    rise = c[1] && !m_cp[d];
    if (c[2]) m_st[d] = din;
    else if (rise && !c[0]) m_st[d] = din;
    m_cp[d] = c[1];
    o  = c[2] ? din : m_st[d];
    oe = !c[3];
  endfunction

  task automatic drive(input logic [W-1:0] da, input logic [W-1:0] db,
                       input logic [3:0] cab, input logic [3:0] cba, input string tag);
    exp_t e;
    @(negedge clk);
    a_i = da;
    b_i = db;
    {ab_oe_ni, ab_le_i, ab_clk_i, ab_ce_ni} = cab;
    {ba_oe_ni, ba_le_i, ba_clk_i, ba_ce_ni} = cba;
    model(0, da, cab, e.b, e.boe);
    model(1, db, cba, e.a, e.aoe);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // the active direction gets ctl; the other one sits in hold with changing data (R1)
  task automatic dr(input int d, input logic [W-1:0] x, input logic [3:0] ctl, input string tag);
    if (d == 0) drive(x, ~x, ctl, HOLD_CTL, tag);
    else        drive(~x, x, HOLD_CTL, ctl, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (a_o !== e.a || a_oe_o !== e.aoe || b_o !== e.b || b_oe_o !== e.boe) begin
          errors++;
          $display("FAIL %s: actual a=%h aoe=%b b=%h boe=%b expected a=%h aoe=%b b=%h boe=%b",
                   e.tag, a_o, a_oe_o, b_o, b_oe_o, e.a, e.aoe, e.b, e.boe);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    {ab_oe_ni, ab_le_i, ab_clk_i, ab_ce_ni} = 4'b0000;
    {ba_oe_ni, ba_le_i, ba_clk_i, ba_ce_ni} = 4'b0000;
    a_i = '1;
    b_i = '1;
    for (int d = 0; d < 2; d++) begin
      m_st[d] = '0;
      m_cp[d] = 1'b0;
    end
    @(posedge clk);
    #2;
    checks++;
    if (a_o !== '0 || b_o !== '0 || a_oe_o !== 1'b0 || b_oe_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 in reset: actual a=%h aoe=%b b=%h boe=%b expected a=0 aoe=0 b=0 boe=0",
               a_o, a_oe_o, b_o, b_oe_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_dir(input int d);
    dr(d, 18'h0_1111, 4'b1100, "R2 drive disabled while transparent");
    dr(d, 18'h1_2345, 4'b0100, "R3 transparent");
    dr(d, 18'h2_6A5C, 4'b0110, "R3 transfer clock ignored");
    dr(d, 18'h3_0F0F, 4'b0101, "R3 clock enable ignored");
    dr(d, 18'h0_BEEF, 4'b0000, "R8 latch enable fall holds");
    dr(d, 18'h1_C001, 4'b0000, "R4 clock steady low");
    dr(d, 18'h2_4242, 4'b0011, "R6 rise with clock enable off");
    dr(d, 18'h3_9999, 4'b0010, "R4 clock steady high");
    dr(d, 18'h0_7777, 4'b0000, "R4 clock falling");
    dr(d, 18'h2_DEAD, 4'b0010, "R5 capture on rise");
    dr(d, 18'h1_0ACE, 4'b0000, "R5 capture held");
    dr(d, 18'h3_3333, 4'b1000, "R2 drive disabled while holding");
    dr(d, 18'h1_5A5A, 4'b1010, "R7 capture while disabled");
    dr(d, 18'h2_2222, 4'b0000, "R7 re-enable shows new word");
    dr(d, 18'h3_FFFF, 4'b0100, "R10 all ones");
    dr(d, 18'h2_0001, 4'b0100, "R10 end bits");
    dr(d, 18'h0_0000, 4'b0000, "R10 hold zero after transparent");
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_ni = 1'b0;
    a_i = '0;
    b_i = '0;
    {ab_oe_ni, ab_le_i, ab_clk_i, ab_ce_ni} = HOLD_CTL;
    {ba_oe_ni, ba_le_i, ba_clk_i, ba_ce_ni} = HOLD_CTL;
    do_reset();
    dr(0, 18'h1_2121, 4'b0000, "R9 cleared after reset");
    run_dir(0); // R1: B-to-A output must hold throughout
    run_dir(1); // R1: A-to-B output must hold throughout
    dr(0, 18'h1_4000, 4'b0100, "R1 load A-to-B before reset");
    do_reset();
    dr(1, 18'h2_1212, 4'b0000, "R9 cleared after mid-run reset");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule